// File: doc/BRIEF.md
# Spin-Lock Requester with Read Polling and Exponential Backoff

This block acquires and releases a lock word held in a shared memory on behalf of one client. The client pulses an acquire command and waits for `granted`. It later pulses a release command. Toward memory the block has one request channel and one response channel. The request carries an operation code: an ordinary read, an atomic test-and-set (the memory returns the old value and leaves 1 in the word), or a store of zero. The response returns a single data bit.

While the lock word reads as taken, the block keeps polling with ordinary reads, so contention stays on cheap reads. It attempts the atomic operation only after a read returns 0. When an atomic attempt returns 1, another requester won the race. The block then waits a delay that doubles after each consecutive failure, up to `MAX_DELAY` cycles, and resumes polling. A successful acquire returns the delay to one cycle. Several copies share one memory through an external arbiter, and mutual exclusion follows from the atomicity of the test-and-set at the memory.

Top module: `spin_lock_requester`

## Requirements
- R1: After reset `granted` is 0 and `mem_req_valid` is 0.
- R2: While reads return 1, only read requests (op code 0) are issued, one after each response. No test-and-set (op code 1) is issued unless the most recent response was a read returning 0.
- R3: A read returning 0 is followed by a test-and-set request. If that returns 0, `granted` is 1 from the cycle after the response.
- R4: A test-and-set that returns 1 sends the block back to read polling after a backoff. It does not assert `granted`.
- R5: The backoff after the k-th consecutive failed test-and-set is min(2^(k-1), MAX_DELAY) cycles. With a memory that accepts and answers at once, the failed test-and-set acceptance is therefore followed by the next read acceptance after backoff+2 cycles.
- R6: A successful acquire resets the backoff, so the first failure of a later acquire waits 1 cycle.
- R7: A release while granted issues one store-zero request (op code 2), and `granted` is 0 from the cycle after the release pulse. The block returns to idle after that store's response.
- R8: A release while not granted, and an acquire while granted, are ignored: no request is issued and `granted` does not change.
- R9: With several requesters on one lock word, at most one is granted in any cycle, and every acquire is eventually granted.
- R10: At most one request is outstanding. A request is held with a stable op code until accepted, and no new request appears until its response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_acquire | input | 1 | Acquire command pulse, taken when idle |
| cmd_release | input | 1 | Release command pulse, taken when granted |
| granted | output | 1 | Lock is held by this client |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_op | output | 2 | 0 read, 1 test-and-set, 2 store zero |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_rsp_valid | input | 1 | Response to the outstanding request |
| mem_rsp_data | input | 1 | Lock value returned (old value for test-and-set) |

## Verification
A corrupted state register appears quickly on the request channel. A spurious test-and-set, a missing read, or a second request while one is outstanding shows up within one response. A wrong backoff counter shows up as a shifted gap between a failed atomic response and the next read, measurable to the cycle. The bench sweeps consecutive-failure counts past the cap, and also checks the gap after a successful acquire. An error in grant tracking appears either as `granted` moving one cycle early or late, or as two requesters granted at once under sustained contention among three requesters.

// File: rtl/spl_pkg.sv
package spl_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_TAS   = 2'd1,
        OP_CLEAR = 2'd2
    } mem_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL,
        ST_TRY,
        ST_BACKOFF,
        ST_HELD,
        ST_FREE
    } lk_state_e;

endpackage

// File: rtl/spl_req_port.sv
module spl_req_port
    import spl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    issue_i,
    input  mem_op_e issue_op_i,
    output logic    mem_req_valid_o,
    output mem_op_e mem_req_op_o,
    input  logic    mem_req_ready_i,
    input  logic    mem_rsp_valid_i,
    input  logic    mem_rsp_data_i,
    output logic    done_o,
    output logic    done_data_o
);

    typedef struct packed {
        logic    pend;
        logic    outst;
        mem_op_e op;
    } port_t;

    port_t port_d, port_q;

    always_comb begin
        port_d = port_q;
        if (port_q.pend && mem_req_ready_i) begin
            port_d.pend  = 1'b0;
            port_d.outst = 1'b1;
        end
        if (port_q.outst && mem_rsp_valid_i) begin
            port_d.outst = 1'b0;
        end
        if (issue_i && !port_q.pend) begin
            port_d.pend = 1'b1;
            port_d.op   = issue_op_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= '{pend: 1'b0, outst: 1'b0, op: OP_READ};
        end else begin
            port_q <= port_d;
        end
    end

    assign mem_req_valid_o = port_q.pend;
    assign mem_req_op_o    = port_q.op;
    assign done_o          = port_q.outst && mem_rsp_valid_i;
    assign done_data_o     = mem_rsp_data_i;

endmodule

// File: rtl/spl_backoff.sv
module spl_backoff #(
    parameter int MAX_DELAY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fail_i,
    input  logic success_i,
    input  logic run_i,
    output logic expire_o
);

    localparam int CW = (MAX_DELAY < 2) ? 1 : $clog2(MAX_DELAY + 1);
    localparam logic [CW:0]   MAX_WIDE = (CW + 1)'(MAX_DELAY);
    localparam logic [CW-1:0] MAX_VAL  = CW'(MAX_DELAY);
    localparam logic [CW-1:0] ONE      = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cur;
        logic [CW-1:0] cnt;
    } bo_t;

    bo_t bo_d, bo_q;
    logic [CW:0] doubled;

    always_comb begin
        bo_d    = bo_q;
        doubled = {bo_q.cur, 1'b0};
        if (run_i && bo_q.cnt > ONE) begin
            bo_d.cnt = bo_q.cnt - ONE;
        end
        if (fail_i) begin
            bo_d.cnt = bo_q.cur;
            if (doubled > MAX_WIDE) begin
                bo_d.cur = MAX_VAL;
            end else begin
                bo_d.cur = doubled[CW-1:0];
            end
        end
        if (success_i) begin
            bo_d.cur = ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bo_q <= '{cur: ONE, cnt: '0};
        end else begin
            bo_q <= bo_d;
        end
    end

    assign expire_o = run_i && (bo_q.cnt <= ONE);

endmodule

// File: rtl/spin_lock_requester.sv
module spin_lock_requester
    import spl_pkg::*;
#(
    parameter int MAX_DELAY = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_acquire,
    input  logic       cmd_release,
    output logic       granted,
    output logic       mem_req_valid,
    output logic [1:0] mem_req_op,
    input  logic       mem_req_ready,
    input  logic       mem_rsp_valid,
    input  logic       mem_rsp_data
);

    typedef struct packed {
        lk_state_e state;
    } fsm_t;

    fsm_t    fsm_d, fsm_q;
    logic    issue;
    mem_op_e issue_op;
    logic    rsp_done;
    logic    rsp_bit;
    logic    bo_fail;
    logic    bo_success;
    logic    bo_run;
    logic    bo_expire;
    mem_op_e req_op_e;

    spl_req_port u_port (
        .clk             (clk),
        .rst_n           (rst_n),
        .issue_i         (issue),
        .issue_op_i      (issue_op),
        .mem_req_valid_o (mem_req_valid),
        .mem_req_op_o    (req_op_e),
        .mem_req_ready_i (mem_req_ready),
        .mem_rsp_valid_i (mem_rsp_valid),
        .mem_rsp_data_i  (mem_rsp_data),
        .done_o          (rsp_done),
        .done_data_o     (rsp_bit)
    );

    spl_backoff #(.MAX_DELAY(MAX_DELAY)) u_backoff (
        .clk       (clk),
        .rst_n     (rst_n),
        .fail_i    (bo_fail),
        .success_i (bo_success),
        .run_i     (bo_run),
        .expire_o  (bo_expire)
    );

    always_comb begin
        fsm_d      = fsm_q;
        issue      = 1'b0;
        issue_op   = OP_READ;
        bo_fail    = 1'b0;
        bo_success = 1'b0;
        bo_run     = 1'b0;
        unique case (fsm_q.state)
            ST_IDLE: begin
                if (cmd_acquire) begin
                    issue       = 1'b1;
                    fsm_d.state = ST_POLL;
                end
            end
            ST_POLL: begin
                if (rsp_done) begin
                    issue = 1'b1;
                    if (!rsp_bit) begin
                        issue_op    = OP_TAS;
                        fsm_d.state = ST_TRY;
                    end
                end
            end
            ST_TRY: begin
                if (rsp_done) begin
                    if (!rsp_bit) begin
                        bo_success  = 1'b1;
                        fsm_d.state = ST_HELD;
                    end else begin
                        bo_fail     = 1'b1;
                        fsm_d.state = ST_BACKOFF;
                    end
                end
            end
            ST_BACKOFF: begin
                bo_run = 1'b1;
                if (bo_expire) begin
                    issue       = 1'b1;
                    fsm_d.state = ST_POLL;
                end
            end
            ST_HELD: begin
                if (cmd_release) begin
                    issue       = 1'b1;
                    issue_op    = OP_CLEAR;
                    fsm_d.state = ST_FREE;
                end
            end
            ST_FREE: begin
                if (rsp_done) begin
                    fsm_d.state = ST_IDLE;
                end
            end
            default: fsm_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q <= '{state: ST_IDLE};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign granted    = (fsm_q.state == ST_HELD);
    assign mem_req_op = req_op_e;

endmodule

// File: rtl/spl_checker.sv
module spl_checker #(
    parameter int MAX_DELAY = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_release,
    input logic       granted,
    input logic       mem_req_valid,
    input logic [1:0] mem_req_op,
    input logic       mem_req_ready,
    input logic       mem_rsp_valid,
    input logic       mem_rsp_data
);

    logic        outst_q;
    logic [1:0]  last_op_q;
    logic        prev_rd0_q;
    logic        gap_on_q;
    logic [31:0] gap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q    <= 1'b0;
            last_op_q  <= 2'd0;
            prev_rd0_q <= 1'b0;
            gap_on_q   <= 1'b0;
            gap_q      <= '0;
        end else begin
            if (gap_on_q) begin
                if (mem_req_valid) gap_on_q <= 1'b0;
                else               gap_q    <= gap_q + 32'd1;
            end
            if (mem_req_valid && mem_req_ready) begin
                outst_q   <= 1'b1;
                last_op_q <= mem_req_op;
            end
            if (outst_q && mem_rsp_valid) begin
                outst_q    <= 1'b0;
                prev_rd0_q <= (last_op_q == 2'd0) && !mem_rsp_data;
                if (last_op_q == 2'd1 && mem_rsp_data) begin
                    gap_on_q <= 1'b1;
                    gap_q    <= '0;
                end
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        $rose(rst_n) |-> !granted && !mem_req_valid); // R1

    AST_TAS_AFTER_FREE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_op == 2'd1) |-> prev_rd0_q); // R2

    AST_GRANT_FROM_TAS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(granted) |-> $past(mem_rsp_valid && !mem_rsp_data && last_op_q == 2'd1)); // R3

    AST_BACKOFF_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        gap_on_q |-> (gap_q <= 32'(MAX_DELAY))); // R5

    AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (granted && cmd_release) |=> !granted); // R7

    AST_CLEAR_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_op == 2'd2) |-> !granted); // R7

    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        outst_q |-> !mem_req_valid); // R10

    AST_REQ_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_op))); // R10

endmodule

bind spin_lock_requester spl_checker #(.MAX_DELAY(MAX_DELAY)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_release   (cmd_release),
    .granted       (granted),
    .mem_req_valid (mem_req_valid),
    .mem_req_op    (mem_req_op),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data)
);

// File: tb/spin_lock_requester_tb_top.sv
module spin_lock_requester_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NREQ       = 3;
    localparam int MAXD       = 8;
    localparam int ROUNDS     = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NREQ-1:0] acq = '0;
    logic [NREQ-1:0] rel = '0;
    logic [NREQ-1:0] granted;
    logic [NREQ-1:0] req_valid;
    logic [1:0]      req_op [NREQ];
    logic [NREQ-1:0] req_ready = '0;
    logic [NREQ-1:0] rsp_valid = '0;
    logic [NREQ-1:0] rsp_data = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic lock_w = 1'b0;
    int fail_tas = 0;
    int log_n = 0;
    int log_cyc [64];
    int log_op [64];
    logic [NREQ-1:0] outst = '0;
    int rr = 0;
    int mx_viol = 0;
    int os_viol = 0;
    int grants [NREQ];

    always #(CLK_PERIOD / 2) clk = ~clk;

    for (genvar g = 0; g < NREQ; g++) begin : g_req
        spin_lock_requester #(.MAX_DELAY(MAXD)) dut_i (
            .clk           (clk),
            .rst_n         (rst_n),
            .cmd_acquire   (acq[g]),
            .cmd_release   (rel[g]),
            .granted       (granted[g]),
            .mem_req_valid (req_valid[g]),
            .mem_req_op    (req_op[g]),
            .mem_req_ready (req_ready[g]),
            .mem_rsp_valid (rsp_valid[g]),
            .mem_rsp_data  (rsp_data[g])
        );
    end

    // shared memory model: one access per cycle, answer one cycle later
    always @(posedge clk) begin
        cyc = cyc + 1;
        for (int i = 0; i < NREQ; i++) begin
            rsp_valid[i] <= 1'b0;
            if (rsp_valid[i]) outst[i] = 1'b0;
            if (rst_n && req_valid[i] && req_ready[i]) begin
                outst[i] = 1'b1;
                rsp_valid[i] <= 1'b1;
                if (i == 0 && log_n < 64) begin
                    log_cyc[log_n] = cyc - 1;
                    log_op[log_n]  = int'(req_op[i]);
                    log_n = log_n + 1;
                end
                case (req_op[i])
                    2'd0: rsp_data[i] <= lock_w;
                    2'd1: begin
                        if (i == 0 && fail_tas > 0) begin
                            rsp_data[i] <= 1'b1;
                            fail_tas = fail_tas - 1;
                        end else begin
                            rsp_data[i] <= lock_w;
                            lock_w = 1'b1;
                        end
                    end
                    default: begin
                        rsp_data[i] <= 1'b0;
                        lock_w = 1'b0;
                    end
                endcase
            end
        end
    end

    // rotating arbiter and per-cycle monitors
    always @(negedge clk) begin
        logic [NREQ-1:0] pick;
        pick = '0;
        for (int k = 0; k < NREQ; k++) begin
            int idx;
            idx = (rr + k) % NREQ;
            if (pick == '0 && req_valid[idx]) begin
                pick[idx] = 1'b1;
                rr = (idx + 1) % NREQ;
            end
        end
        req_ready = pick;
        if (rst_n) begin
            if ($countones(granted) > 1) mx_viol = mx_viol + 1;
            if ((granted != '0) && !lock_w) mx_viol = mx_viol + 1;
            if ((req_valid & outst) != '0) os_viol = os_viol + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_acq(input int id);
        @(negedge clk) acq[id] = 1'b1;
        @(negedge clk) acq[id] = 1'b0;
    endtask

    task automatic pulse_rel(input int id);
        @(negedge clk) rel[id] = 1'b1;
        @(negedge clk) rel[id] = 1'b0;
    endtask

    task automatic wait_grant(input int id, output bit got);
        got = 1'b0;
        for (int t = 0; t < 400; t++) begin
            @(negedge clk);
            if (granted[id]) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    task automatic run_client(input int id, input int hold);
        bit got;
        for (int r = 0; r < ROUNDS; r++) begin
            pulse_acq(id);
            wait_grant(id, got);
            if (got) grants[id] = grants[id] + 1;
            repeat (hold) @(negedge clk);
            pulse_rel(id);
            repeat (2) @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        bit got;
        int n0;
        int gc;
        for (int i = 0; i < NREQ; i++) grants[i] = 0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(granted == '0, "R1 granted after reset", int'(granted), 0);
        check(req_valid == '0, "R1 request after reset", int'(req_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(req_valid == '0, "R1 quiet after reset release", int'(req_valid), 0);

        // R2: lock held elsewhere, only reads spaced by two cycles
        lock_w = 1'b1;
        log_n = 0;
        pulse_acq(0);
        repeat (30) @(negedge clk);
        check(log_n >= 10, "R2 poll read count", log_n, 10);
        begin
            int bad_op;
            int bad_gap;
            bad_op = 0;
            bad_gap = 0;
            for (int k = 0; k < log_n; k++) begin
                if (log_op[k] != 0) bad_op = bad_op + 1;
                if (k > 0 && log_cyc[k] - log_cyc[k-1] != 2) bad_gap = bad_gap + 1;
            end
            check(bad_op == 0, "R2 no test-and-set while busy", bad_op, 0);
            check(bad_gap == 0, "R2 read spacing", bad_gap, 0);
        end
        check(granted[0] == 1'b0, "R2 not granted while busy", int'(granted[0]), 0);

        // R3: lock freed, test-and-set then grant one cycle after response
        n0 = log_n;
        lock_w = 1'b0;
        wait_grant(0, got);
        gc = cyc;
        check(got, "R3 grant obtained", int'(got), 1);
        check(log_op[log_n-1] == 1, "R3 last op test-and-set", log_op[log_n-1], 1);
        check(log_op[log_n-2] == 0, "R3 op before it is a read", log_op[log_n-2], 0);
        check(gc == log_cyc[log_n-1] + 2, "R3 grant timing", gc, log_cyc[log_n-1] + 2);
        check(n0 < log_n, "R3 new requests issued", log_n, n0 + 2);

        // R8: acquire while granted ignored
        n0 = log_n;
        pulse_acq(0);
        repeat (6) @(negedge clk);
        check(log_n == n0, "R8 acquire while held issues nothing", log_n, n0);
        check(granted[0] == 1'b1, "R8 still granted", int'(granted[0]), 1);

        // R7: release stores zero and drops grant
        n0 = log_n;
        @(negedge clk) rel[0] = 1'b1;
        @(negedge clk) rel[0] = 1'b0;
        check(granted[0] == 1'b0, "R7 grant dropped after release", int'(granted[0]), 0);
        repeat (4) @(negedge clk);
        check(log_n == n0 + 1, "R7 one request on release", log_n, n0 + 1);
        check(log_op[n0] == 2, "R7 release op code", log_op[n0], 2);
        check(lock_w == 1'b0, "R7 lock word cleared", int'(lock_w), 0);

        // R8: release while idle ignored
        n0 = log_n;
        pulse_rel(0);
        pulse_rel(1);
        repeat (6) @(negedge clk);
        check(log_n == n0, "R8 release while idle issues nothing", log_n, n0);
        check(req_valid == '0 && granted == '0, "R8 idle outputs", int'(req_valid | granted), 0);

        // R4 R5: five consecutive atomic failures, cap reached
        log_n = 0;
        fail_tas = 5;
        pulse_acq(0);
        wait_grant(0, got);
        check(got, "R4 grant after failures", int'(got), 1);
        check(log_n == 12, "R4 request count", log_n, 12);
        for (int j = 0; j < 6; j++) begin
            check(log_op[2*j] == 0 && log_op[2*j+1] == 1, "R4 read/tas alternation",
                  log_op[2*j] * 4 + log_op[2*j+1], 1);
        end
        for (int j = 0; j < 5; j++) begin
            int d;
            d = ((1 << j) > MAXD) ? MAXD : (1 << j);
            check(log_cyc[2*j+2] - log_cyc[2*j+1] == d + 2, "R5 backoff gap",
                  log_cyc[2*j+2] - log_cyc[2*j+1], d + 2);
        end
        pulse_rel(0);
        repeat (4) @(negedge clk);

        // R6: backoff reset after a successful acquire
        log_n = 0;
        fail_tas = 1;
        pulse_acq(0);
        wait_grant(0, got);
        check(got && log_n == 4, "R6 grant after one failure", log_n, 4);
        check(log_cyc[2] - log_cyc[1] == 3, "R6 backoff back to one cycle",
              log_cyc[2] - log_cyc[1], 3);
        pulse_rel(0);
        repeat (4) @(negedge clk);

        // R9: three requesters contending
        fork
            run_client(0, 3);
            run_client(1, 5);
            run_client(2, 7);
        join
        for (int i = 0; i < NREQ; i++) begin
            check(grants[i] == ROUNDS, "R9 every acquire granted", grants[i], ROUNDS);
        end
        check(mx_viol == 0, "R9 mutual exclusion", mx_viol, 0);
        check(os_viol == 0, "R10 single outstanding request", os_viol, 0);
        check(lock_w == 1'b0, "R9 lock free at end", int'(lock_w), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule